// File: doc/BRIEF.md
# Lowest-PC Thread Vote for a Lockstep Warp

This block keeps a program counter and a call-nesting depth for each thread of one warp. It elects the single address the warp fetches from next, called the master PC, and reports which threads take part in the instruction at that address. The only divergence state is the per-thread PC and depth. There is no reconvergence stack: threads that went down different paths are merged again as soon as their PCs meet.

The election favours the threads that sit deepest in the call nesting. Among those, the one with the smallest PC wins, so threads that lag behind can catch up. A balanced tree of pairwise comparators computes the result. A row of equality comparators then marks as active every live thread whose PC equals the master PC. When the issue stage reports a sequential (non-branch) instruction, the active threads step their PCs and the master PC steps with them, with no new election. When it reports a control transfer, the active threads load their resolved targets, depths and exit flags from per-lane inputs. The following cycle is spent re-electing. A thread whose exit flag is set leaves the warp. When no thread is left, the block raises a done flag.

Top module: `mpv_warp_vote`

## Requirements
- R1: While `rst` is high, `master_pc` equals `START_PC`, `active_mask` is 0 and `ready` and `warp_done` are 0. In the first cycle after reset is released, `ready` stays 0. In the cycle after that, all lanes are active at `START_PC` and `ready` is 1.
- R2: An accepted issue with `issue_op` = 0 (sequential) advances `master_pc` by 4 in the next cycle, and `ready` stays 1.
- R3: A lane that is not active when an instruction is accepted keeps its PC and depth unchanged.
- R4: An accepted issue with `issue_op` = 1 (control transfer) loads each active lane's PC, depth and exit flag from its slice of `tgt_pc`, `tgt_depth` and `tgt_exit`. Lane i uses bits [i*32 +: 32], [i*4 +: 4] and bit i. `ready` is 0 in the next cycle only.
- R5: The cycle after that, `master_pc` is the lowest PC among the live lanes of greatest depth. A deeper lane wins over any shallower one, whatever the PCs.
- R6: Right after an election, `active_mask` bit i is 1 exactly when lane i is live and its PC equals `master_pc`. Whenever `ready` is 1, `active_mask` is nonzero.
- R7: After a sequential step, lanes that stay active remain set. Any live inactive lane whose PC equals the new `master_pc` joins `active_mask`.
- R8: Exited lanes take no part in the election and never appear in `active_mask`.
- R9: `warp_done` is 1 exactly when every lane has exited. `ready` is then 0 and the mask becomes 0 once the last election completes.
- R10: `issue_valid` has no effect in any cycle where `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction at `master_pc` is issued this cycle |
| issue_op | input | 1 | 0 = sequential step, 1 = control transfer |
| tgt_pc | input | LANES*32 | Resolved target PC per lane |
| tgt_depth | input | LANES*4 | Call depth after the transfer, per lane |
| tgt_exit | input | LANES | Lane leaves the warp on this transfer |
| ready | output | 1 | An instruction may be issued |
| master_pc | output | 32 | Elected fetch address |
| active_mask | output | LANES | Lanes executing the instruction at `master_pc` |
| warp_done | output | 1 | All lanes have exited |

## Verification
The hardest state to reach is one where two groups meet again through sequential stepping alone. A lagging group has to reach the PC of a waiting group, and a deeper group has to hold a higher PC than a shallower one. The stimulus first splits the warp with a control transfer that sends one half a few words behind the other. It then steps the lagging half until it lands on the waiting half's address. A second transfer gives a lane subset a larger depth with a higher PC, a third lane the same large depth with a lower PC, and the rest a low PC at depth zero. A behavioural model with its own election loop then follows random transfers, exits and blocked issue attempts.

// File: rtl/mpv_pkg.sv
package mpv_pkg;

    localparam int PC_W    = 32;
    localparam int DEP_W   = 4;
    localparam int PC_STEP = 4;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [DEP_W-1:0] dep_t;

    typedef enum logic {
        OP_SEQ  = 1'b0,
        OP_JUMP = 1'b1
    } op_e;

    // One contender in the election
    typedef struct packed {
        logic live;
        dep_t dep;
        pc_t  pc;
    } cand_t;

    // True when a is at least as good as b: live first, then deeper, then lower PC
    function automatic logic prefer(cand_t a, cand_t b);
        if (a.live != b.live) return a.live;
        if (a.dep != b.dep)   return a.dep > b.dep;
        return a.pc <= b.pc;
    endfunction

    function automatic cand_t pick(cand_t a, cand_t b);
        return prefer(a, b) ? a : b;
    endfunction

endpackage

// File: rtl/mpv_lane_bank.sv
module mpv_lane_bank
    import mpv_pkg::*;
#(
    parameter int  LANES    = 8,
    parameter pc_t START_PC = 32'h0000_0100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_go,
    input  logic                   jump_go,
    input  logic [LANES-1:0]       act,
    input  logic [LANES*PC_W-1:0]  tgt_pc,
    input  logic [LANES*DEP_W-1:0] tgt_depth,
    input  logic [LANES-1:0]       tgt_exit,
    output pc_t                    pc_q [LANES],
    output cand_t                  cand [LANES],
    output logic [LANES-1:0]       gone
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pc_t  pc_r;
        dep_t dep_r;
        logic ex_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                pc_r  <= START_PC;
                dep_r <= '0;
                ex_r  <= 1'b0;
            end else if (act[i] && step_go) begin
                pc_r <= pc_r + pc_t'(PC_STEP);
            end else if (act[i] && jump_go) begin
                pc_r  <= tgt_pc[i*PC_W +: PC_W];
                dep_r <= tgt_depth[i*DEP_W +: DEP_W];
                ex_r  <= tgt_exit[i];
            end
        end

        assign pc_q[i] = pc_r;
        assign gone[i] = ex_r;
        assign cand[i] = '{live: ~ex_r, dep: dep_r, pc: pc_r};
    end

endmodule

// File: rtl/mpv_min_tree.sv
module mpv_min_tree
    import mpv_pkg::*;
#(
    parameter int LANES = 8
) (
    input  cand_t leaf [LANES],
    output cand_t root
);

    localparam int LEVELS = $clog2(LANES);

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lv
        cand_t v [LANES >> lv];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < LANES; i++) begin : g_in
                assign v[i] = leaf[i];
            end
        end else begin : g_cmp
            for (genvar j = 0; j < (LANES >> lv); j++) begin : g_node
                assign v[j] = pick(g_lv[lv-1].v[2*j], g_lv[lv-1].v[2*j+1]);
            end
        end
    end

    assign root = g_lv[LEVELS].v[0];

endmodule

// File: rtl/mpv_match_row.sv
module mpv_match_row
    import mpv_pkg::*;
#(
    parameter int LANES = 8
) (
    input  pc_t              pc_q [LANES],
    input  logic [LANES-1:0] gone,
    input  pc_t              ref_pc,
    output logic [LANES-1:0] hit
);

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign hit[i] = ~gone[i] && (pc_q[i] == ref_pc);
    end

endmodule

// File: rtl/mpv_warp_vote.sv
module mpv_warp_vote
    import mpv_pkg::*;
#(
    parameter int  LANES    = 8,
    parameter pc_t START_PC = 32'h0000_0100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue_valid,
    input  logic                   issue_op,
    input  logic [LANES*PC_W-1:0]  tgt_pc,
    input  logic [LANES*DEP_W-1:0] tgt_depth,
    input  logic [LANES-1:0]       tgt_exit,
    output logic                   ready,
    output logic [PC_W-1:0]        master_pc,
    output logic [LANES-1:0]       active_mask,
    output logic                   warp_done
);

    logic             vote_q;
    pc_t              mpc_q;
    logic [LANES-1:0] act_q;

    pc_t              pc_q [LANES];
    cand_t            cand [LANES];
    logic [LANES-1:0] gone;
    cand_t            root;
    logic [LANES-1:0] hit;
    pc_t              mpc_step;
    pc_t              ref_pc;
    logic             accept, step_go, jump_go;

    assign warp_done = &gone;
    assign ready     = ~vote_q & ~warp_done;
    assign accept    = issue_valid & ready;
    assign step_go   = accept && (op_e'(issue_op) == OP_SEQ);
    assign jump_go   = accept && (op_e'(issue_op) == OP_JUMP);
    assign mpc_step  = mpc_q + pc_t'(PC_STEP);
    assign ref_pc    = vote_q ? root.pc : mpc_step;

    mpv_lane_bank #(.LANES(LANES), .START_PC(START_PC)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .step_go   (step_go),
        .jump_go   (jump_go),
        .act       (act_q),
        .tgt_pc    (tgt_pc),
        .tgt_depth (tgt_depth),
        .tgt_exit  (tgt_exit),
        .pc_q      (pc_q),
        .cand      (cand),
        .gone      (gone)
    );

    mpv_min_tree #(.LANES(LANES)) u_tree (
        .leaf (cand),
        .root (root)
    );

    mpv_match_row #(.LANES(LANES)) u_match (
        .pc_q   (pc_q),
        .gone   (gone),
        .ref_pc (ref_pc),
        .hit    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vote_q <= 1'b1;
            mpc_q  <= START_PC;
            act_q  <= '0;
        end else if (vote_q) begin
            vote_q <= 1'b0;
            if (root.live) begin
                mpc_q <= root.pc;
                act_q <= hit;
            end else begin
                act_q <= '0;
            end
        end else if (step_go) begin
            mpc_q <= mpc_step;
            act_q <= act_q | hit;
        end else if (jump_go) begin
            vote_q <= 1'b1;
        end
    end

    assign master_pc   = mpc_q;
    assign active_mask = act_q;

endmodule

// File: rtl/mpv_vote_checker.sv
module mpv_vote_checker
    import mpv_pkg::*;
#(
    parameter int  LANES    = 8,
    parameter pc_t START_PC = 32'h0000_0100
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic             issue_op,
    input logic             ready,
    input logic [PC_W-1:0]  master_pc,
    input logic [LANES-1:0] active_mask,
    input logic             warp_done
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ready && active_mask == '0 && master_pc == START_PC));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && ready && issue_op == 1'b0)
        |=> (master_pc == pc_t'($past(master_pc) + pc_t'(PC_STEP)) && ready));

    p_jump_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && ready && issue_op == 1'b1) |=> (!ready && $stable(master_pc)));

    p_ready_has_lane_r6: assert property (@(posedge clk) disable iff (rst)
        ready |-> (active_mask != '0));

    p_seq_keeps_lanes_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && ready && issue_op == 1'b0)
        |=> ((active_mask & $past(active_mask)) == $past(active_mask)));

    p_done_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        warp_done |-> !ready);

    p_done_sticks_r9: assert property (@(posedge clk) disable iff (rst)
        warp_done |=> (warp_done && $stable(master_pc)));

    p_blocked_issue_r10: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready) && issue_valid) |=> $stable(master_pc));

endmodule

bind mpv_warp_vote mpv_vote_checker #(.LANES(LANES), .START_PC(START_PC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .ready       (ready),
    .master_pc   (master_pc),
    .active_mask (active_mask),
    .warp_done   (warp_done)
);

// File: tb/mpv_warp_vote_bench.sv
`timescale 1ns/1ps
module mpv_warp_vote_bench;
    import mpv_pkg::*;

    localparam int  N     = 8;
    localparam pc_t START = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_valid = 1'b0;
    logic issue_op = 1'b0;
    logic [N*PC_W-1:0]  tgt_pc = '0;
    logic [N*DEP_W-1:0] tgt_depth = '0;
    logic [N-1:0]       tgt_exit = '0;
    logic               ready, warp_done;
    logic [PC_W-1:0]    master_pc;
    logic [N-1:0]       active_mask;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    mpv_warp_vote #(.LANES(N), .START_PC(START)) u_mpv_warp_vote (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .tgt_pc(tgt_pc), .tgt_depth(tgt_depth), .tgt_exit(tgt_exit),
        .ready(ready), .master_pc(master_pc), .active_mask(active_mask),
        .warp_done(warp_done)
    );

    // Behavioural reference
    logic [31:0] m_pc [N];
    int          m_dep [N];
    bit          m_ex [N];
    logic [31:0] m_mpc;
    logic [N-1:0] m_mask;
    bit          m_pend;

    function automatic bit m_done();
        foreach (m_ex[i]) if (!m_ex[i]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_pc[i]) begin m_pc[i] = START; m_dep[i] = 0; m_ex[i] = 0; end
            m_mpc = START; m_mask = '0; m_pend = 1;
        end else if (m_pend) begin
            int best;
            best = -1;
            m_pend = 0;
            for (int i = 0; i < N; i++) begin
                if (!m_ex[i]) begin
                    if (best < 0 || m_dep[i] > m_dep[best] ||
                        (m_dep[i] == m_dep[best] && m_pc[i] < m_pc[best]))
                        best = i;
                end
            end
            m_mask = '0;
            if (best >= 0) begin
                m_mpc = m_pc[best];
                for (int i = 0; i < N; i++) m_mask[i] = !m_ex[i] && (m_pc[i] == m_mpc);
            end
        end else if (!m_done() && issue_valid) begin
            if (issue_op == 1'b0) begin
                for (int i = 0; i < N; i++) if (m_mask[i]) m_pc[i] = m_pc[i] + 4;
                m_mpc = m_mpc + 4;
                for (int i = 0; i < N; i++) if (!m_ex[i] && m_pc[i] == m_mpc) m_mask[i] = 1'b1;
            end else begin
                for (int i = 0; i < N; i++) if (m_mask[i]) begin
                    m_pc[i]  = tgt_pc[i*PC_W +: PC_W];
                    m_dep[i] = int'(tgt_depth[i*DEP_W +: DEP_W]);
                    m_ex[i]  = tgt_exit[i];
                end
                m_pend = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (!ended && total > 0) begin
            chk(master_pc == m_mpc, "R5 model master_pc", master_pc, m_mpc);
            chk(active_mask == m_mask, "R6 model active_mask", 32'(active_mask), 32'(m_mask));
            chk(ready == (!m_pend && !m_done()), "R4 model ready", 32'(ready), 32'(!m_pend && !m_done()));
            chk(warp_done == m_done(), "R9 model warp_done", 32'(warp_done), 32'(m_done()));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic go(input bit op);
        issue_valid = 1'b1; issue_op = op;
        step();
        issue_valid = 1'b0;
    endtask

    task automatic aim(input int l, input logic [31:0] pc, input int dep, input bit ex);
        tgt_pc[l*PC_W +: PC_W]      = pc;
        tgt_depth[l*DEP_W +: DEP_W] = DEP_W'(dep);
        tgt_exit[l]                 = ex;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 50000);
        total++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        chk(master_pc == START, "R1 reset master_pc", master_pc, START);
        chk(active_mask == 0 && !ready && !warp_done, "R1 reset outputs",
            {active_mask, 8'(ready), 8'(warp_done)}, 0);
        rst = 1'b0;
        step();
        chk(active_mask == 8'hFF && ready, "R1 all lanes active", 32'(active_mask), 32'hFF);

        repeat (3) go(0);
        chk(master_pc == 32'h10C && ready, "R2 sequential steps", master_pc, 32'h10C);

        for (int l = 0; l < 4; l++) aim(l, 32'h200, 0, 0);
        for (int l = 4; l < 8; l++) aim(l, 32'h180, 0, 0);
        go(1);
        chk(!ready, "R4 bubble after transfer", 32'(ready), 0);
        step();
        chk(master_pc == 32'h180, "R5 lowest pc wins", master_pc, 32'h180);
        chk(active_mask == 8'hF0, "R6 split mask", 32'(active_mask), 32'hF0);

        for (int l = 4; l < 8; l++) aim(l, 32'h1F8, 0, 0);
        go(1); step();
        go(0);
        chk(active_mask == 8'hF0, "R3 waiting lanes stay out", 32'(active_mask), 32'hF0);
        go(0);
        chk(master_pc == 32'h200 && active_mask == 8'hFF, "R7 lanes rejoin on step",
            32'(active_mask), 32'hFF);

        for (int l = 0; l < 8; l++) aim(l, 32'h300, 0, 0);
        aim(0, 32'h400, 2, 0); aim(1, 32'h400, 2, 0); aim(2, 32'h380, 2, 0);
        go(1);
        issue_valid = 1'b1; issue_op = 1'b0;
        step();
        issue_valid = 1'b0;
        chk(master_pc == 32'h380, "R10 blocked issue ignored / R5 depth wins", master_pc, 32'h380);
        chk(active_mask == 8'h04, "R5 deepest lowest lane", 32'(active_mask), 32'h04);

        aim(2, 32'h0, 0, 1);
        go(1); step();
        chk(master_pc == 32'h400 && active_mask == 8'h03, "R8 exited lane left out",
            master_pc, 32'h400);
        aim(0, 32'h0, 0, 1); aim(1, 32'h0, 0, 1);
        go(1); step();
        chk(master_pc == 32'h300 && active_mask == 8'hF8, "R8 shallow group resumes",
            32'(active_mask), 32'hF8);
        for (int l = 3; l < 8; l++) aim(l, 32'h0, 0, 1);
        go(1);
        chk(warp_done && !ready, "R9 done raised", 32'(warp_done), 1);
        step();
        chk(active_mask == 0, "R9 mask cleared", 32'(active_mask), 0);
        go(0);
        chk(master_pc == 32'h300 && !ready, "R9 done ignores issue", master_pc, 32'h300);

        rst = 1'b1; step(); rst = 1'b0; step();
        for (int it = 0; it < 1500; it++) begin
            if (warp_done) begin
                rst = 1'b1; step(); rst = 1'b0;
            end
            for (int l = 0; l < N; l++)
                aim(l, 32'h100 + 4 * ($urandom % 12), int'($urandom % 3), ($urandom % 12) == 0);
            issue_valid = ($urandom % 4) != 0;
            issue_op = ($urandom % 3) == 0;
            step();
            issue_valid = 1'b0;
        end
        finish_run();
    end

endmodule